// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

The block is one stage of a synchronous binary counter, `W` bits wide (4 by default), that wraps modulo 2^W. On each rising clock edge it either takes a value from a parallel data bus, steps up by one, steps down by one, or keeps its value. A direction input picks up or down. Three active-low inputs control the stage: a load enable that takes priority over everything else, and two count enables that must both be low for the stage to count.

One of the count enables is a carry input. It also gates an active-low terminal-count flag. That flag is a purely combinational output. It goes low when the carry input is low and the count sits at the terminal value for the current direction: all ones when counting up, all zeros when counting down. To build a wider counter, connect each stage's flag to the carry input of the next more significant stage, and share the clock, direction, load and plain count-enable lines across all stages. The enable then ripples forward within the same cycle, and every stage steps on the same edge.

Each edge applies one of four named operations:

- `OP_LOAD`: load is low.
- `OP_HOLD`: load is high and either enable is high.
- `OP_UP`: load is high, both enables are low, and the direction input is high.
- `OP_DOWN`: load is high, both enables are low, and the direction input is low.

The stage has no reset. Its count is undefined until the first load.

Top module: `ucnt_stage`

## Requirements
- R1: The count changes only on a rising clock edge. A change of any input between edges leaves the count unchanged.
- R2: When `load_n` is 0 at an edge, the count becomes `din`. This holds whatever the values of `cnt_en_n`, `carry_in_n` and `dir_up`.
- R3: When `load_n` is 1 and either `cnt_en_n` or `carry_in_n` is 1 at an edge, the count keeps its value.
- R4: When `load_n`, `cnt_en_n` and `carry_in_n` are 1, 0, 0 and `dir_up` is 1, the count increments by one. The maximum value (all ones) wraps to 0.
- R5: Under the same enables with `dir_up` at 0, the count decrements by one. A count of 0 wraps to the maximum value (all ones).
- R6: `term_n` is 1 whenever `carry_in_n` is 1. It is 0 only when `carry_in_n` is 0 and the count equals the terminal value: all ones if `dir_up` is 1, all zeros if `dir_up` is 0.
- R7: `term_n` follows changes on `carry_in_n` and `dir_up` without waiting for a clock edge.
- R8: Two chained stages form a 2W-bit counter. The low stage's `term_n` feeds the high stage's `carry_in_n`. This counter increments, decrements and wraps across the stage boundary, including when the direction reverses at a terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| din | input | W | Parallel value taken on load |
| load_n | input | 1 | Active-low synchronous load, highest priority |
| cnt_en_n | input | 1 | Active-low count enable |
| carry_in_n | input | 1 | Active-low count enable that also gates `term_n` |
| count | output | W | Present count |
| term_n | output | 1 | Active-low terminal-count flag, combinational |

## Verification
The bound checker applies the following rules on every cycle after the first load:

- the load effect of R2;
- the hold rule of R3;
- the increment and decrement of R4 and R5, each with modular wrap;
- the gating of `term_n` by the carry input (R6);
- the rule that a low `term_n` only ever appears at all ones or all zeros.

Some behaviours need the bench's scenarios instead. These are:

- the absence of change between edges (R1);
- the same-cycle response of `term_n` to the direction and carry inputs (R7);
- the behaviour of a two-stage chain, where a carry crosses the boundary or the direction reverses at a terminal value (R8).

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

    // Operation applied at the next rising edge
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } op_e;

endpackage

// File: rtl/ucnt_op_decode.sv
module ucnt_op_decode
    import ucnt_pkg::*;
(
    input  logic load_n,
    input  logic cnt_en_n,
    input  logic carry_in_n,
    input  logic dir_up,
    output op_e  op
);

    // Load wins over both enables; either enable high freezes the count
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (cnt_en_n || carry_in_n) begin
            op = OP_HOLD;
        end else if (dir_up) begin
            op = OP_UP;
        end else begin
            op = OP_DOWN;
        end
    end

endmodule

// File: rtl/ucnt_state_reg.sv
module ucnt_state_reg
    import ucnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  op_e          op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] STEP = W'(1);

    // No reset: the value is undefined until the first load
    always_ff @(posedge clk) begin
        unique case (op)
            OP_LOAD: q <= din;
            OP_UP:   q <= q + STEP;
            OP_DOWN: q <= q - STEP;
            OP_HOLD: q <= q;
            default: q <= q;
        endcase
    end

endmodule

// File: rtl/ucnt_term_detect.sv
module ucnt_term_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         dir_up,
    input  logic         carry_in_n,
    output logic         term_n
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] BOT_VAL = '0;

    logic at_end;

    always_comb begin
        at_end = dir_up ? (q == TOP_VAL) : (q == BOT_VAL);
        term_n = carry_in_n | ~at_end;
    end

endmodule

// File: rtl/ucnt_stage.sv
module ucnt_stage
    import ucnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         dir_up,
    input  logic [W-1:0] din,
    input  logic         load_n,
    input  logic         cnt_en_n,
    input  logic         carry_in_n,
    output logic [W-1:0] count,
    output logic         term_n
);

    op_e op;

    ucnt_op_decode u_dec (
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .carry_in_n (carry_in_n),
        .dir_up     (dir_up),
        .op         (op)
    );

    ucnt_state_reg #(.W(W)) u_reg (
        .clk (clk),
        .op  (op),
        .din (din),
        .q   (count)
    );

    ucnt_term_detect #(.W(W)) u_term (
        .q          (count),
        .dir_up     (dir_up),
        .carry_in_n (carry_in_n),
        .term_n     (term_n)
    );

endmodule

// File: rtl/ucnt_stage_chk.sv
module ucnt_stage_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         dir_up,
    input logic [W-1:0] din,
    input logic         load_n,
    input logic         cnt_en_n,
    input logic         carry_in_n,
    input logic [W-1:0] count,
    input logic         term_n
);

    // Checks start only once a load has defined the count
    logic seen_load = 1'b0;
    always_ff @(posedge clk) begin
        if (!load_n) seen_load <= 1'b1;
    end

    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!seen_load)
        !load_n |=> count == $past(din)); // R2

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!seen_load)
        (load_n && (cnt_en_n || carry_in_n)) |=> $stable(count)); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!seen_load)
        (load_n && !cnt_en_n && !carry_in_n && dir_up) |=> count == W'($past(count) + 1'b1)); // R4

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!seen_load)
        (load_n && !cnt_en_n && !carry_in_n && !dir_up) |=> count == W'($past(count) - 1'b1)); // R5

    AST_CARRY_GATES: assert property (@(posedge clk) disable iff (!seen_load)
        carry_in_n |-> term_n); // R6

    AST_TERM_AT_END: assert property (@(posedge clk) disable iff (!seen_load)
        !term_n |-> (count == {W{1'b1}} || count == '0)); // R6

endmodule

bind ucnt_stage ucnt_stage_chk #(.W(W)) u_chk (
    .clk        (clk),
    .dir_up     (dir_up),
    .din        (din),
    .load_n     (load_n),
    .cnt_en_n   (cnt_en_n),
    .carry_in_n (carry_in_n),
    .count      (count),
    .term_n     (term_n)
);

// File: tb/ucnt_stage_tb.sv
module ucnt_stage_tb;

    localparam int W = 4;
    localparam int NV = 19;

    logic         clk = 1'b0;
    logic         dir_up = 1'b1;
    logic [2*W-1:0] din = '0;
    logic         load_n = 1'b1;
    logic         en_n = 1'b1;
    logic         cin_n = 1'b1;
    logic [W-1:0] cnt_lo, cnt_hi;
    logic         term_lo, term_hi;
    logic [2*W-1:0] wide;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ucnt_stage #(.W(W)) u_dut (
        .clk (clk), .dir_up (dir_up), .din (din[W-1:0]), .load_n (load_n),
        .cnt_en_n (en_n), .carry_in_n (cin_n), .count (cnt_lo), .term_n (term_lo)
    );

    ucnt_stage #(.W(W)) u_dut_hi (
        .clk (clk), .dir_up (dir_up), .din (din[2*W-1:W]), .load_n (load_n),
        .cnt_en_n (en_n), .carry_in_n (term_lo), .count (cnt_hi), .term_n (term_hi)
    );

    assign wide = {cnt_hi, cnt_lo};

    // {load_n, en_n, cin_n, dir_up, din, expected 8-bit count after the edge}
    localparam logic [19:0] VEC [0:NV-1] = '{
        {1'b0, 1'b1, 1'b1, 1'b1, 8'h0C, 8'h0C},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h0D},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h0E},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h0F},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h10},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h11},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h12},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h12},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h12},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'hFE, 8'hFE},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFE},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 8'h10},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h10},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R1 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Table walk: drive at falling edge, sample at the next falling edge
        for (int i = 0; i < NV; i++) begin
            {load_n, en_n, cin_n, dir_up, din} = VEC[i][19:8];
            @(negedge clk);
            if (!load_n)              chk("R2 R8 load", wide, VEC[i][7:0]);
            else if (en_n || cin_n)   chk("R3 R8 hold", wide, VEC[i][7:0]);
            else if (dir_up)          chk("R4 R8 up", wide, VEC[i][7:0]);
            else                      chk("R5 R8 down", wide, VEC[i][7:0]);
        end

        // Count is now 0xFF; flag follows inputs with no clock edge
        load_n = 1'b1; en_n = 1'b1; cin_n = 1'b0; dir_up = 1'b1;
        #1 chk("R7 term low at max going up", {7'd0, term_lo}, 8'd0);
        chk("R8 high stage terminal via carry", {7'd0, term_hi}, 8'd0);
        dir_up = 1'b0;
        #1 chk("R7 term high at max going down", {7'd0, term_lo}, 8'd1);
        cin_n = 1'b1; dir_up = 1'b1;
        #1 chk("R6 carry high gates term", {7'd0, term_lo}, 8'd1);
        chk("R6 gated chain", {7'd0, term_hi}, 8'd1);

        // No change between edges even with load asserted
        @(negedge clk);
        load_n = 1'b0; din = 8'h55; en_n = 1'b0; cin_n = 1'b0;
        #2 chk("R1 stable between edges", wide, 8'hFF);
        @(negedge clk);
        chk("R2 load overrides enables", wide, 8'h55);

        // Bottom terminal when counting down
        load_n = 1'b0; din = 8'h00; dir_up = 1'b0; en_n = 1'b1; cin_n = 1'b1;
        @(negedge clk);
        load_n = 1'b1; cin_n = 1'b0;
        #1 chk("R6 term low at zero going down", {7'd0, term_lo}, 8'd0);
        chk("R8 high stage at zero going down", {7'd0, term_hi}, 8'd0);
        dir_up = 1'b1;
        #1 chk("R7 term high at zero going up", {7'd0, term_lo}, 8'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule